// File: doc/BRIEF.md
# Blank-Skipping Flash Erase Sequencer

This block erases an aligned address range of a serial NOR flash through a byte-wide command port toward an SPI master. It takes one request that carries a start offset, a byte count and the address width in use (three or four address bytes). The request is then cut into erase steps. Each step is either a 64 KiB block or a 4 KiB sector: the block form is used when the current offset sits on a 64 KiB boundary and at least 64 KiB are still left. Before every step, and once more after the last one, the sequencer polls the flash status register until the busy flag clears.

When blank checking is enabled, each step first reads its whole region back in frames of a fixed chunk length. The bytes are grouped into 32-bit words and each word is compared against all ones. At the first word that is not all ones the check stops and a real erase follows. If every word is all ones, no write enable and no erase command are sent, and the range simply advances. A transfer error during this read-back is not reported: the step falls back to a normal erase.

A real erase first sends write enable, then reads status and confirms that the write-enable latch is set. Only then does it send the erase opcode followed by the address, most significant byte first. The requester sees a single-cycle done pulse, with an error flag that is valid in the same cycle.

Top module: `blank_skip_eraser`

## Requirements
- R1: A request whose offset or size is not a multiple of 4096, or whose size is below 4096, produces done with err high in the cycle right after acceptance, and no SPI byte is requested.
- R2: Before each step, and after the final step, the sequencer sends a two-byte status frame (opcode 0x05, then a dummy byte). It repeats this frame as long as bit 0 (busy) of the second received byte is 1, and sends no read or erase frame while busy.
- R3: With block erase enabled, a step uses opcode 0xD8 and covers 65536 bytes when the current offset is a multiple of 65536 and at least 65536 bytes remain. Otherwise the step uses opcode 0x20 and covers 4096 bytes.
- R4: With blank checking enabled, each step is read back in frames of opcode 0x03, the address and MAX_READ data bytes. The last flag is set on the final data byte, and the frame addresses run upward from the step offset in strides of MAX_READ.
- R5: The read-back stops at the first 32-bit word that is not 0xFFFFFFFF. If that word does not end the frame, the frame is closed with a one-cycle abort pulse. A real erase of the step follows.
- R6: When every word of a step reads 0xFFFFFFFF, no write enable and no erase frame are sent for that step, and the sequence moves on to the next step.
- R7: An error acknowledged during a read-back frame leads to a normal erase of that step, and err stays low at done if the rest succeeds.
- R8: Each erase frame is preceded by a one-byte 0x06 frame and a status frame. If bit 1 of that status byte is 0, the request ends with err high and no erase frame is sent.
- R9: Erase and read frames carry the address most significant byte first: four bytes when the wide-address input was high at the request, three bytes (the low 24 bits) otherwise.
- R10: done is a one-cycle pulse that appears only after the final status poll reads not busy. err is low on success, and the block accepts a new request in the cycle after done.
- R11: A byte request holds its data and last flag unchanged until it is acknowledged.
- R12: An error acknowledged in a status, write-enable or erase frame ends the request with err high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_offset | input | ADDR_W | Start byte offset of the range |
| req_size | input | SIZE_W | Byte count of the range |
| req_wide_addr | input | 1 | 1 selects four address bytes, 0 selects three |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| spi_req | output | 1 | A byte transfer is requested |
| spi_tx | output | 8 | Byte to shift out |
| spi_last | output | 1 | Release chip select after this byte |
| spi_abort | output | 1 | One-cycle pulse that releases chip select with no byte |
| spi_ack | input | 1 | Requested byte transferred this cycle |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| spi_err | input | 1 | Transfer failed, valid with spi_ack, ends the frame |

## Verification
A rejected request must raise done in the first cycle after the edge that accepted it. The bench samples done at the falling edge that follows that acceptance edge, not at any later point. Every byte is acknowledged in the same cycle it is requested, and the flash model answers at falling edges, so each status byte, read byte and error reaches the sequencer at the next rising edge. Accepted requests are judged at the first falling edge where done is seen. At that point the bench compares the logged erase opcodes and addresses, the frame and abort counts and the number of status polls against values it works out from the offset, the size and the set of dirty sectors, using the step rule of R3.

// File: rtl/erz_pkg.sv
package erz_pkg;
    // Flash opcodes sent by the sequencer
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_SEC_ER = 8'h20;
    localparam logic [7:0] OP_BLK_ER = 8'hD8;

    // Status register bit positions
    localparam int BUSY_BIT  = 0;
    localparam int LATCH_BIT = 1;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_PLAN, S_SCAN, S_CUT,
        S_WREN, S_WCHK, S_ERASE, S_ADV, S_DONE
    } erz_state_t;
endpackage

// File: rtl/erz_req_gate.sv
// Request validity check.
// Does: flags a request whose offset and size are whole sectors and whose
// size is at least one sector.
// Assumes: the sector size is a power of two (2**SECT_LG2 bytes).
module erz_req_gate #(
    parameter int SIZE_W   = 32,
    parameter int SECT_LG2 = 12
) (
    input  logic [SECT_LG2-1:0] off_lo,
    input  logic [SIZE_W-1:0]   size,
    output logic                ok
);
    localparam logic [SIZE_W-1:0] SECT_SZ = SIZE_W'(1) << SECT_LG2;

    // Alignment and minimum-length test
    always_comb begin
        ok = (off_lo == '0) && (size[SECT_LG2-1:0] == '0) && (size >= SECT_SZ);
    end
endmodule

// File: rtl/erz_step_sel.sv
// Erase granularity selector.
// Does: picks a block step when the offset is block aligned and a whole
// block remains, otherwise a sector step; block steps can be compiled out.
// Assumes: the offset is already sector aligned.
module erz_step_sel #(
    parameter int SIZE_W   = 32,
    parameter int SECT_LG2 = 12,
    parameter int BLK_LG2  = 16,
    parameter bit BLOCK_EN = 1'b1
) (
    input  logic [BLK_LG2-1:0] off_lo,
    input  logic [SIZE_W-1:0]  remain,
    output logic               use_blk,
    output logic [SIZE_W-1:0]  step
);
    localparam logic [SIZE_W-1:0] SECT_SZ = SIZE_W'(1) << SECT_LG2;
    localparam logic [SIZE_W-1:0] BLK_SZ  = SIZE_W'(1) << BLK_LG2;

    generate
        if (BLOCK_EN) begin : g_blk
            // Block step when aligned and enough bytes remain
            always_comb use_blk = (off_lo == '0) && (remain >= BLK_SZ);
        end else begin : g_sect
            logic unused_in;
            // Sector-only variant
            always_comb begin
                unused_in = ^{off_lo, remain};
                use_blk   = 1'b0;
            end
        end
    endgenerate

    // Step length follows the chosen granularity
    always_comb step = use_blk ? BLK_SZ : SECT_SZ;
endmodule

// File: rtl/erz_word_cmp.sv
// Blank word comparator.
// Does: groups incoming bytes into words and flags, on the last byte of a
// word, whether that word differs from all ones.
// Assumes: clr is raised before the first data byte of every frame.
module erz_word_cmp #(
    parameter int WORD_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       vld,
    input  logic [7:0] byte_in,
    output logic       miss
);
    localparam int PW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(WORD_BYTES - 1);

    logic [PW-1:0] pos;
    logic [7:0]    acc;

    // Mismatch decided on the closing byte of each word
    always_comb miss = vld && (pos == LAST_POS) && ((acc & byte_in) != 8'hFF);

    // Byte position and running AND of the word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos <= '0;
            acc <= 8'hFF;
        end else if (vld) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
            acc <= (pos == LAST_POS) ? 8'hFF : (acc & byte_in);
        end
    end
endmodule

// File: rtl/blank_skip_eraser.sv
// Blank-skipping erase sequencer (top).
// Does: splits an aligned range into sector or block erase steps, polls busy
// before each step and at the end, optionally reads a step back and skips it
// when blank, and otherwise sends write enable, checks the latch and erases.
// Assumes: MAX_READ is a power of two from 4 up to the sector size; the SPI
// master releases chip select after a byte flagged last or acknowledged with
// an error, and on an abort pulse.
module blank_skip_eraser #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 32,
    parameter int SECT_LG2 = 12,
    parameter int BLK_LG2  = 16,
    parameter int MAX_READ = 256,
    parameter bit BLANK_EN = 1'b1,
    parameter bit BLOCK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_wide_addr,
    output logic              done,
    output logic              err,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    output logic              spi_last,
    output logic              spi_abort,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    input  logic              spi_err
);
    import erz_pkg::*;

    localparam int BW = $clog2(MAX_READ + 8);
    localparam logic [SIZE_W-1:0] CHUNK  = SIZE_W'(MAX_READ);
    localparam logic [SIZE_W-1:0] BLK_SZ = SIZE_W'(1) << BLK_LG2;
    localparam logic [BW-1:0] DATA_END   = BW'(MAX_READ - 1);

    erz_state_t        st;
    logic [ADDR_W-1:0] cur_off;
    logic [SIZE_W-1:0] remain;
    logic [SIZE_W-1:0] step_r;
    logic              wide;
    logic              blk_r;
    logic [ADDR_W-1:0] chk_off;
    logic [SIZE_W-1:0] chk_left;
    logic [BW-1:0]     bidx;
    logic              err_r;

    logic              req_ok;
    logic              sel_blk;
    logic [SIZE_W-1:0] sel_step;
    logic [BW-1:0]     hl;
    logic              data_byte;
    logic              took;
    logic              cmp_miss;
    logic              cmp_clr;
    logic              cmp_vld;

    erz_req_gate #(.SIZE_W(SIZE_W), .SECT_LG2(SECT_LG2)) u_gate (
        .off_lo (req_offset[SECT_LG2-1:0]),
        .size   (req_size),
        .ok     (req_ok)
    );

    erz_step_sel #(
        .SIZE_W(SIZE_W), .SECT_LG2(SECT_LG2),
        .BLK_LG2(BLK_LG2), .BLOCK_EN(BLOCK_EN)
    ) u_sel (
        .off_lo  (cur_off[BLK_LG2-1:0]),
        .remain  (remain),
        .use_blk (sel_blk),
        .step    (sel_step)
    );

    erz_word_cmp #(.WORD_BYTES(4)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmp_clr),
        .vld     (cmp_vld),
        .byte_in (spi_rx),
        .miss    (cmp_miss)
    );

    // Pick one address byte, most significant first, for frame position idx
    function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a,
                                             input logic [BW-1:0] idx,
                                             input logic [BW-1:0] h);
        int sh;
        sh = 8 * (int'(h) - 1 - int'(idx));
        if (sh < 0) sh = 0;
        return 8'(a >> sh);
    endfunction

    // Frame header length and handshake helpers
    always_comb begin
        hl        = wide ? BW'(5) : BW'(4);
        data_byte = (st == S_SCAN) && (bidx >= hl);
        took      = spi_req && spi_ack;
        cmp_clr   = (st == S_SCAN) && !data_byte;
        cmp_vld   = data_byte && spi_ack && !spi_err;
    end

    // Handshake and command port outputs
    always_comb begin
        req_ready = (st == S_IDLE);
        done      = (st == S_DONE);
        err       = (st == S_DONE) && err_r;
        spi_abort = (st == S_CUT);
        spi_req   = (st == S_POLL) || (st == S_WCHK) || (st == S_WREN) ||
                    (st == S_ERASE) || (st == S_SCAN);
    end

    // Byte to send and frame end flag for the current state
    always_comb begin
        spi_tx   = 8'h00;
        spi_last = 1'b0;
        unique case (st)
            S_POLL, S_WCHK: begin
                spi_tx   = (bidx == '0) ? OP_RDSR : 8'h00;
                spi_last = (bidx != '0);
            end
            S_WREN: begin
                spi_tx   = OP_WREN;
                spi_last = 1'b1;
            end
            S_ERASE: begin
                spi_tx   = (bidx == '0) ? (blk_r ? OP_BLK_ER : OP_SEC_ER)
                                        : addr_byte(cur_off, bidx, hl);
                spi_last = (bidx == hl - 1'b1);
            end
            S_SCAN: begin
                if (bidx == '0)    spi_tx = OP_READ;
                else if (bidx < hl) spi_tx = addr_byte(chk_off, bidx, hl);
                spi_last = (bidx == hl + DATA_END);
            end
            default: ;
        endcase
    end

    // Sequencer state, range tracking and frame byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cur_off  <= '0;
            remain   <= '0;
            step_r   <= '0;
            wide     <= 1'b0;
            blk_r    <= 1'b0;
            chk_off  <= '0;
            chk_left <= '0;
            bidx     <= '0;
            err_r    <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (req_valid) begin
                    bidx <= '0;
                    if (req_ok) begin
                        cur_off <= req_offset;
                        remain  <= req_size;
                        wide    <= req_wide_addr;
                        err_r   <= 1'b0;
                        st      <= S_POLL;
                    end else begin
                        err_r <= 1'b1;
                        st    <= S_DONE;
                    end
                end
                S_POLL: if (took) begin
                    if (spi_err) begin
                        err_r <= 1'b1;
                        st    <= S_DONE;
                    end else if (bidx == '0) begin
                        bidx <= bidx + 1'b1;
                    end else begin
                        bidx <= '0;
                        if (!spi_rx[BUSY_BIT])
                            st <= (remain == '0) ? S_DONE : S_PLAN;
                    end
                end
                S_PLAN: begin
                    blk_r    <= sel_blk;
                    step_r   <= sel_step;
                    chk_off  <= cur_off;
                    chk_left <= sel_step;
                    bidx     <= '0;
                    st       <= BLANK_EN ? S_SCAN : S_WREN;
                end
                S_SCAN: if (took) begin
                    if (spi_err) begin
                        bidx <= '0;
                        st   <= S_WREN;
                    end else if (cmp_miss) begin
                        bidx <= '0;
                        st   <= spi_last ? S_WREN : S_CUT;
                    end else if (spi_last) begin
                        bidx     <= '0;
                        chk_off  <= chk_off + ADDR_W'(CHUNK);
                        chk_left <= chk_left - CHUNK;
                        if (chk_left == CHUNK) st <= S_ADV;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                S_CUT: st <= S_WREN;
                S_WREN: if (took) begin
                    bidx <= '0;
                    if (spi_err) begin
                        err_r <= 1'b1;
                        st    <= S_DONE;
                    end else begin
                        st <= S_WCHK;
                    end
                end
                S_WCHK: if (took) begin
                    if (spi_err) begin
                        err_r <= 1'b1;
                        st    <= S_DONE;
                    end else if (bidx == '0) begin
                        bidx <= bidx + 1'b1;
                    end else begin
                        bidx <= '0;
                        if (spi_rx[LATCH_BIT]) begin
                            st <= S_ERASE;
                        end else begin
                            err_r <= 1'b1;
                            st    <= S_DONE;
                        end
                    end
                end
                S_ERASE: if (took) begin
                    if (spi_err) begin
                        err_r <= 1'b1;
                        st    <= S_DONE;
                    end else if (spi_last) begin
                        bidx <= '0;
                        st   <= S_ADV;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                S_ADV: begin
                    cur_off <= cur_off + ADDR_W'(step_r);
                    remain  <= remain - step_r;
                    st      <= S_POLL;
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1
    bad_req_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready &&
         ((req_offset[SECT_LG2-1:0] != '0) || (req_size[SECT_LG2-1:0] != '0) ||
          (req_size < (SIZE_W'(1) << SECT_LG2))))
        |=> (done && err));

    // R11
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx) && $stable(spi_last)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R5
    abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_abort |-> (!spi_req && $past(spi_req) && !$past(spi_last)));

    // R3
    block_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ERASE && bidx == '0 && spi_req && spi_tx == OP_BLK_ER)
        |-> (cur_off[BLK_LG2-1:0] == '0 && remain >= BLK_SZ));
endmodule

// File: tb/test_blank_skip_eraser.sv
module test_blank_skip_eraser;
    localparam int MAXR = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_offset = '0;
    logic [31:0] req_size = '0;
    logic        req_wide_addr = 1'b0;
    logic        done, err;
    logic        spi_req, spi_last, spi_abort;
    logic [7:0]  spi_tx;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = 8'h00;
    logic        spi_err = 1'b0;

    always #2 clk = ~clk;

    blank_skip_eraser #(.MAX_READ(MAXR)) i_blank_skip_eraser (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_size(req_size),
        .req_wide_addr(req_wide_addr),
        .done(done), .err(err),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last),
        .spi_abort(spi_abort), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .spi_err(spi_err)
    );

    int n_chk = 0;
    int n_err = 0;

    // flash model state
    bit          dirty [64];
    int unsigned dpos = 0;
    int          busy = 0;
    int          erase_busy = 1;
    bit          wel = 0;
    bit          refuse_wel = 0;
    int          inj_rd = 0;
    bit          inj_er = 0;
    bit          m4 = 0;
    int          fb = 0;
    logic [7:0]  op = 8'h00;
    int unsigned fa = 0;
    // logs
    logic [7:0]  er_op [64];
    int unsigned er_ad [64];
    int          n_er = 0;
    int          rd_frames = 0;
    int          aborts = 0;
    int          n_stat = 0;
    int          n_wren = 0;
    int          viol = 0;
    int unsigned last_rd_ad = 0;
    // expectations
    logic [7:0]  ex_op [64];
    int unsigned ex_ad [64];
    int          n_ex = 0;
    bit          got_err = 0;

    function automatic logic [7:0] byte_val(input int unsigned a);
        return (dirty[(a >> 12) & 63] && ((a & 32'hFFF) == dpos)) ? 8'h00 : 8'hFF;
    endfunction

    // Flash model: answers each requested byte at the falling edge
    always @(negedge clk) begin
        int nal;
        spi_ack = 1'b0;
        spi_err = 1'b0;
        spi_rx  = 8'h00;
        nal = m4 ? 4 : 3;
        if (rst_n && spi_abort) begin
            if (op == 8'h03) rd_frames++;
            aborts++;
            fb = 0;
        end else if (rst_n && spi_req) begin
            spi_ack = 1'b1;
            if (fb == 0) begin
                op = spi_tx;
                fa = 0;
            end else if (fb <= nal && (op == 8'h03 || op == 8'h20 || op == 8'hD8)) begin
                fa = (fa << 8) | spi_tx;
            end
            if (op == 8'h03 && fb > nal) begin
                spi_rx = byte_val(fa + fb - nal - 1);
                if (busy != 0) viol++;
                if (fb == nal + 1) last_rd_ad = fa;
                if (inj_rd > 0) begin
                    inj_rd--;
                    if (inj_rd == 0) spi_err = 1'b1;
                end
            end
            if (op == 8'h05 && fb == 1) begin
                spi_rx = {6'b0, wel, busy != 0};
                if (busy > 0) busy--;
                n_stat++;
            end
            if ((op == 8'h20 || op == 8'hD8) && spi_last && inj_er) begin
                spi_err = 1'b1;
                inj_er = 0;
            end
            if (spi_err || spi_last) begin
                if (op == 8'h06 && !spi_err) begin
                    wel = !refuse_wel;
                    n_wren++;
                end
                if (op == 8'h03) begin
                    rd_frames++;
                    if (!spi_err && fb != nal + MAXR) viol++;
                end
                if ((op == 8'h20 || op == 8'hD8) && !spi_err) begin
                    if (!wel || busy != 0) viol++;
                    er_op[n_er & 63] = op;
                    er_ad[n_er & 63] = fa;
                    n_er++;
                    for (int k = 0; k < ((op == 8'hD8) ? 16 : 1); k++)
                        dirty[((fa >> 12) + k) & 63] = 0;
                    busy = erase_busy;
                    wel = 0;
                end
                fb = 0;
            end else begin
                fb++;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_er = 0; rd_frames = 0; aborts = 0; n_stat = 0; n_wren = 0; viol = 0;
    endtask

    task automatic set_all_dirty(input bit v);
        for (int k = 0; k < 64; k++) dirty[k] = v;
    endtask

    // Expected erase list from the step rule and the dirty map
    task automatic plan(input int unsigned off, input int unsigned size, input bit wide);
        int unsigned o, r, sz;
        bit blk, clean;
        n_ex = 0; o = off; r = size;
        while (r > 0) begin
            blk = (o % 65536 == 0) && (r >= 65536);
            sz = blk ? 65536 : 4096;
            clean = 1;
            for (int k = 0; k < int'(sz / 4096); k++)
                if (dirty[((o >> 12) + k) & 63]) clean = 0;
            if (!clean) begin
                ex_op[n_ex] = blk ? 8'hD8 : 8'h20;
                ex_ad[n_ex] = wide ? o : (o & 32'hFFFFFF);
                n_ex++;
            end
            o += sz; r -= sz;
        end
    endtask

    task automatic run(input int unsigned off, input int unsigned size, input bit wide);
        int cyc;
        clear_log();
        m4 = wide;
        @(negedge clk);
        req_offset = off; req_size = size; req_wide_addr = wide; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) check("watchdog request", 0, 1);
        got_err = err;
        @(negedge clk);
    endtask

    task automatic compare_log(input string tag);
        check({tag, " erase count"}, n_er, n_ex);
        for (int k = 0; k < n_ex && k < n_er; k++) begin
            check({tag, " opcode"}, er_op[k], ex_op[k]);
            check({tag, " address"}, er_ad[k], ex_ad[k]);
        end
        check({tag, " protocol violations"}, viol, 0);
    endtask

    task automatic run_bad(input int unsigned off, input int unsigned size);
        clear_log();
        @(negedge clk);
        req_offset = off; req_size = size; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 done next cycle", done, 1);
        check("R1 err with done", err, 1);
        @(negedge clk);
        check("R1 ready again", req_ready, 1);
        check("R1 no SPI traffic", n_stat + rd_frames + n_er + n_wren, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        set_all_dirty(0);
        repeat (4) @(negedge clk);
        check("reset ready", req_ready, 1);
        check("reset done", done, 0);
        check("reset spi_req", spi_req, 0);
        rst_n = 1'b1;

        // R1: rejections
        run_bad(32'h800, 32'h1000);
        run_bad(32'h0, 32'h0);
        run_bad(32'h0, 32'h1800);
        run_bad(32'h1000, 32'h800);

        // R3 R9: sweep of offsets and sizes, every sector dirty at word 0
        dpos = 0;
        for (int oi = 0; oi < 32; oi += 3) begin
            for (int si = 0; si < 4; si++) begin
                int unsigned sz;
                sz = (si == 0) ? 32'h1000 : (si == 1) ? 32'h10000 :
                     (si == 2) ? 32'h11000 : 32'h21000;
                set_all_dirty(1);
                plan(oi * 32'h1000, sz, oi[0]);
                run(oi * 32'h1000, sz, oi[0]);
                check("R3 sweep err", got_err, 0);
                compare_log("R3 R9 sweep");
            end
        end

        // R9: four address bytes above 16 MiB
        set_all_dirty(0);
        dirty[(32'h01234000 >> 12) & 63] = 1;
        plan(32'h01234000, 32'h1000, 1);
        run(32'h01234000, 32'h1000, 1);
        compare_log("R9 wide");

        // R6 R4: clean sector is read back and skipped
        set_all_dirty(0);
        run(32'h5000, 32'h1000, 0);
        check("R6 no erase", n_er, 0);
        check("R6 no write enable", n_wren, 0);
        check("R4 frame count", rd_frames, 4096 / MAXR);
        check("R4 last frame address", last_rd_ad, 32'h5000 + 4096 - MAXR);
        check("R6 err", got_err, 0);
        check("R4 violations", viol, 0);

        // R5: dirty last byte checks every frame, then erases
        dirty[6] = 1; dpos = 32'hFFF;
        run(32'h6000, 32'h1000, 0);
        check("R5 frames", rd_frames, 4096 / MAXR);
        check("R5 aborts", aborts, 0);
        check("R5 erase", n_er, 1);

        // R5: mismatch in the middle of the second frame ends it early
        dirty[7] = 1; dpos = 32'h104;
        run(32'h7000, 32'h1000, 0);
        check("R5 early frames", rd_frames, 2);
        check("R5 abort pulse", aborts, 1);
        check("R5 early erase", n_er, 1);

        // R6: whole clean block skipped
        set_all_dirty(0);
        run(32'h20000, 32'h10000, 0);
        check("R6 block no erase", n_er, 0);
        check("R6 block frames", rd_frames, 65536 / MAXR);

        // R7: read error falls back to erase without error
        inj_rd = 5;
        run(32'h3000, 32'h1000, 0);
        check("R7 erase done", n_er, 1);
        check("R7 err low", got_err, 0);
        check("R7 frames", rd_frames, 1);

        // R8: latch refused
        dirty[2] = 1; dpos = 0; refuse_wel = 1;
        run(32'h2000, 32'h1000, 0);
        check("R8 err", got_err, 1);
        check("R8 no erase", n_er, 0);
        refuse_wel = 0;

        // R12: error on erase frame
        dirty[2] = 1; inj_er = 1;
        run(32'h2000, 32'h1000, 0);
        check("R12 err", got_err, 1);
        check("R12 no erase logged", n_er, 0);

        // R2 R10: busy before start and after erase
        dirty[9] = 1; busy = 2; erase_busy = 3;
        run(32'h9000, 32'h1000, 0);
        check("R2 status polls", n_stat, 8);
        check("R10 not busy at done", busy, 0);
        check("R2 no access while busy", viol, 0);
        check("R10 err", got_err, 0);
        erase_busy = 1;

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule